// File: doc/BRIEF.md
# Multichannel I2S Serializer Transmitter

This block is a master-mode audio serializer. It takes 32-bit sample words from a valid/ready stream and shifts them out, most significant bit first, on one to four serial data lanes. It also drives the bit clock and the frame clock itself. Timing comes from a single-cycle `bit_tick_i` pulse, supplied by an external divider, inside the `clk_i` domain. Each tick toggles the bit clock, so one bit period lasts two ticks. A frame is 64 bit periods long: a 32-bit left slot followed by a 32-bit right slot.

The frame can follow standard I2S format, with the data delayed by one bit and the frame clock low on the left slot. It can also be left-justified, with no delay and the frame clock high on the left slot. The bit clock and the frame clock can each be inverted. Samples are either 16 or 32 bits wide. The block works in stereo (one lane) or eight-channel mode (four stereo lanes sharing one frame clock). A hold input silences the output from the next frame boundary and stops sample intake, while both clocks keep running. A soft reset restarts the frame at bit 0 of the left slot.

Top module: `i2s_mc_tx`

## Requirements
- R1: While `rst_ni` is low and just after reset: `sd_o` is 0, `s_ready_o` is 1 (with `hold_i` low), and the un-inverted bit clock is low. The frame clock shows its left-slot level.
- R2: `bclk_o` toggles on each cycle `bit_tick_i` is high and holds otherwise. Data changes only on the un-inverted falling transition. One frame is 64 bit periods.
- R3: The un-inverted frame clock is high for the 32 left-slot bit periods in left-justified mode (`fmt_i2s_i`=0) and low for them in I2S mode (`fmt_i2s_i`=1). `lrclk_inv_i`=1 inverts it further. It changes only at slot boundaries.
- R4: `bclk_inv_i`=1 inverts `bclk_o`, independently of the frame clock inversion.
- R5: Each slot is sent MSB first. In left-justified mode the MSB falls in the first bit period of its slot. In I2S mode it falls one bit period later, and the right slot's LSB falls in bit period 0 of the next frame.
- R6: With `wide_i`=1 all 32 bits of a word are sent. With `wide_i`=0, bits [15:0] are sent, followed by 16 zero bits.
- R7: Stereo mode (`chan8_i`=0) takes two words per frame, left then right, on `sd_o[0]`. `sd_o[3:1]` stay 0.
- R8: Eight-channel mode (`chan8_i`=1) takes eight words per frame. Word 2n is the left slot and word 2n+1 the right slot of lane `sd_o[n]`.
- R9: The block buffers exactly one frame of words, then holds `s_ready_o` low until that frame starts at the next frame boundary. A frame with no complete buffer is sent as zeros, so the first frame after a reset or soft reset is silent.
- R10: `hold_i` is sampled at each frame boundary. A held frame sends zeros on every lane, accepts no words, and keeps both clocks running.
- R11: A one-cycle `soft_rst_i` discards any partly buffered words and the shift data. The next cycle starts at bit 0 of the left slot with the un-inverted bit clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous pipeline restart |
| bit_tick_i | input | 1 | Half-bit-period enable from the divider |
| fmt_i2s_i | input | 1 | 1: I2S format, 0: left-justified |
| bclk_inv_i | input | 1 | Invert the bit clock output |
| lrclk_inv_i | input | 1 | Invert the frame clock output |
| chan8_i | input | 1 | 1: eight channels on four lanes, 0: stereo |
| wide_i | input | 1 | 1: 32-bit samples, 0: 16-bit samples |
| hold_i | input | 1 | Silence the stream from the next frame boundary |
| s_valid_i | input | 1 | Sample word valid |
| s_data_i | input | 32 | Sample word |
| s_ready_o | output | 1 | Sample word accepted when high with valid |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| sd_o | output | 4 | Serial data, one bit per lane |

## Verification
The bench decodes the serial lines from the ports and compares whole frames against words it packs itself. It covers:
- stereo in I2S format at 32 bits, which separates one-bit skew from none and shows that the unused lanes stay quiet;
- stereo left-justified at 16 bits with both clocks inverted, which exposes polarity handling and zero padding;
- eight channels in both formats, which shows whether word-to-lane mapping and slot order are right;
- a slowed tick, a partial buffer before a soft reset, and a hold window during which a word is offered, which separate clock pacing, discarded staging and refused intake from plain data errors.

// File: rtl/i2s_mc_tx_pkg.sv
package i2s_mc_tx_pkg;
  localparam int SKEW_W   = 2;
  localparam int MAX_SKEW = 3;
  localparam logic [SKEW_W-1:0] SKEW_LJ  = 2'd0;
  localparam logic [SKEW_W-1:0] SKEW_I2S = 2'd1;

  typedef struct packed {
    logic [SKEW_W-1:0] skew;
    logic              lr_inv;   // frame clock flip, format adjusted
    logic              bclk_inv;
    logic              wide;
    logic              multi;
  } tx_cfg_t;
endpackage

// File: rtl/i2s_mc_tx_clk.sv
module i2s_mc_tx_clk #(
  parameter int SLOT_BITS  = 32,
  parameter int FRAME_BITS = 2 * SLOT_BITS,
  parameter int CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             tick_i,
  input  logic             bclk_inv_i,
  input  logic             lr_inv_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             adv_o,
  output logic             frame_o,
  output logic [CNT_W-1:0] bit_idx_o
);
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lr_left;

  assign adv_o     = tick_i & phase_q;
  assign frame_o   = adv_o & (cnt_q == CNT_W'(FRAME_BITS - 1));
  assign bit_idx_o = cnt_q;
  assign lr_left   = (cnt_q < CNT_W'(SLOT_BITS));
  assign bclk_o    = phase_q ^ bclk_inv_i;
  assign lrclk_o   = lr_left ^ lr_inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (soft_rst_i) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (tick_i) begin
      phase_q <= ~phase_q;
      if (phase_q) cnt_q <= frame_o ? '0 : cnt_q + 1'b1;
    end
  end

  AST_FRAME_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lr_left) |-> (cnt_q == '0 || cnt_q == CNT_W'(SLOT_BITS))); // R3

  AST_BCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !soft_rst_i |=> ((bclk_o != $past(bclk_o)) || !$stable(bclk_inv_i))); // R2
endmodule

// File: rtl/i2s_mc_tx_stage.sv
module i2s_mc_tx_stage #(
  parameter int SAMPLE_W = 32,
  parameter int NCH_MAX  = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              soft_rst_i,
  input  logic                              multi_i,
  input  logic                              held_i,
  input  logic                              load_i,
  input  logic                              valid_i,
  input  logic [SAMPLE_W-1:0]               data_i,
  output logic                              ready_o,
  output logic                              full_o,
  output logic [NCH_MAX-1:0][SAMPLE_W-1:0]  words_o
);
  localparam int CW = $clog2(NCH_MAX + 1);
  localparam int IW = $clog2(NCH_MAX);

  logic [CW-1:0]                     cnt_q;
  logic [CW-1:0]                     nch;
  logic [NCH_MAX-1:0][SAMPLE_W-1:0]  words_q;

  assign nch     = multi_i ? CW'(NCH_MAX) : CW'(2);
  assign full_o  = (cnt_q >= nch);
  assign ready_o = ~held_i & ~full_o & ~soft_rst_i;
  assign words_o = words_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      words_q <= '0;
    end else if (soft_rst_i || load_i) begin
      cnt_q <= '0;
    end else if (valid_i && ready_o) begin
      words_q[cnt_q[IW-1:0]] <= data_i;
      cnt_q                  <= cnt_q + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NCH_MAX)); // R9

  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !load_i && !soft_rst_i |=> $stable(words_q)); // R9
endmodule

// File: rtl/i2s_mc_tx_lane.sv
module i2s_mc_tx_lane #(
  parameter int SAMPLE_W = 32,
  parameter int NARROW_W = 16,
  parameter int MAX_SKEW = 3,
  parameter int SKW      = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                adv_i,
  input  logic                frame_i,
  input  logic                fill_i,
  input  logic                en_i,
  input  logic                wide_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic [SKW-1:0]      skew_i,
  output logic                sd_o
);
  localparam int FRAME_BITS = 2 * SAMPLE_W;
  localparam int PAD_W      = SAMPLE_W - NARROW_W;

  function automatic logic [SAMPLE_W-1:0] fit(input logic [SAMPLE_W-1:0] w, input logic wide);
    return wide ? w : {w[NARROW_W-1:0], {PAD_W{1'b0}}};
  endfunction

  logic [FRAME_BITS-1:0] sh_q;
  logic [MAX_SKEW-1:0]   dly_q;
  logic [MAX_SKEW:0]     taps;

  // tap 0 is the undelayed bit, tap k is k bit periods late
  assign taps = {dly_q, sh_q[FRAME_BITS-1]};
  assign sd_o = taps[skew_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      dly_q <= '0;
    end else if (soft_rst_i) begin
      sh_q  <= '0;
      dly_q <= '0;
    end else if (adv_i) begin
      dly_q <= taps[MAX_SKEW-1:0];
      if (frame_i) sh_q <= (fill_i && en_i) ? {fit(left_i, wide_i), fit(right_i, wide_i)} : '0;
      else         sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/i2s_mc_tx.sv
module i2s_mc_tx
  import i2s_mc_tx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int NARROW_W = 16,
  parameter int LANES    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                bit_tick_i,
  input  logic                fmt_i2s_i,
  input  logic                bclk_inv_i,
  input  logic                lrclk_inv_i,
  input  logic                chan8_i,
  input  logic                wide_i,
  input  logic                hold_i,
  input  logic                s_valid_i,
  input  logic [SAMPLE_W-1:0] s_data_i,
  output logic                s_ready_o,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic [LANES-1:0]    sd_o
);
  localparam int NCH_MAX    = 2 * LANES;
  localparam int FRAME_BITS = 2 * SAMPLE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  tx_cfg_t                          cfg;
  logic                             adv, frame_evt, full, load, hold_q;
  logic [CNT_W-1:0]                 bit_idx;
  logic [NCH_MAX-1:0][SAMPLE_W-1:0] words;

  always_comb begin
    cfg.skew     = fmt_i2s_i ? SKEW_I2S : SKEW_LJ;
    cfg.lr_inv   = lrclk_inv_i ^ fmt_i2s_i;
    cfg.bclk_inv = bclk_inv_i;
    cfg.wide     = wide_i;
    cfg.multi    = chan8_i;
  end

  // a buffered frame starts only at a boundary that is not held
  assign load = frame_evt & full & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_q <= 1'b0;
    else if (soft_rst_i || frame_evt) hold_q <= hold_i;
  end

  i2s_mc_tx_clk #(.SLOT_BITS(SAMPLE_W)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .tick_i     (bit_tick_i),
    .bclk_inv_i (cfg.bclk_inv),
    .lr_inv_i   (cfg.lr_inv),
    .bclk_o     (bclk_o),
    .lrclk_o    (lrclk_o),
    .adv_o      (adv),
    .frame_o    (frame_evt),
    .bit_idx_o  (bit_idx)
  );

  i2s_mc_tx_stage #(.SAMPLE_W(SAMPLE_W), .NCH_MAX(NCH_MAX)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .multi_i    (cfg.multi),
    .held_i     (hold_q),
    .load_i     (load),
    .valid_i    (s_valid_i),
    .data_i     (s_data_i),
    .ready_o    (s_ready_o),
    .full_o     (full),
    .words_o    (words)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    i2s_mc_tx_lane #(
      .SAMPLE_W (SAMPLE_W),
      .NARROW_W (NARROW_W),
      .MAX_SKEW (MAX_SKEW),
      .SKW      (SKEW_W)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst_i),
      .adv_i      (adv),
      .frame_i    (frame_evt),
      .fill_i     (load),
      .en_i       ((g == 0) || cfg.multi),
      .wide_i     (cfg.wide),
      .left_i     (words[2*g]),
      .right_i    (words[2*g+1]),
      .skew_i     (cfg.skew),
      .sd_o       (sd_o[g])
    );
  end

  AST_HELD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && (bit_idx > CNT_W'(MAX_SKEW)) |-> sd_o == '0); // R10
endmodule

// File: tb/i2s_mc_tx_bench.sv
module i2s_mc_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, bit_tick = 1'b0;
  logic        cfg_i2s = 1'b1, cfg_binv = 1'b0, cfg_linv = 1'b0, cfg_c8 = 1'b0, cfg_wide = 1'b1;
  logic        hold = 1'b0, s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, bclk, lrclk;
  logic [3:0]  sd;

  int total = 0, fails = 0, tick_div = 1, tk = 0;
  int clr_req = 0, clr_seen = 0, nfr = 0, idx = -1, last_len = 0;
  logic        prev_lvl = 1'b0, prev_lr = 1'b0, lvl, lr;
  logic [63:0] rx [4];
  logic [63:0] fr [64][4];
  logic [31:0] exp_w [64];

  always #2 clk = ~clk;

  i2s_mc_tx u_i2s_mc_tx (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .bit_tick_i(bit_tick),
    .fmt_i2s_i(cfg_i2s), .bclk_inv_i(cfg_binv), .lrclk_inv_i(cfg_linv),
    .chan8_i(cfg_c8), .wide_i(cfg_wide), .hold_i(hold),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .bclk_o(bclk), .lrclk_o(lrclk), .sd_o(sd));

  initial forever begin
    @(negedge clk);
    tk++;
    bit_tick = ((tk % tick_div) == 0);
  end

  // port-level decoder: records one 64-bit word per lane per frame
  always @(negedge clk) begin
    if (clr_req != clr_seen) begin
      clr_seen = clr_req; nfr = 0; idx = -1; last_len = 0;
      prev_lvl = 1'b0; prev_lr = 1'b0;
      for (int l = 0; l < 4; l++) rx[l] = '0;
    end
    lvl = bclk ^ cfg_binv;
    lr  = lrclk ^ cfg_linv ^ cfg_i2s;
    if (rst_n && lvl && !prev_lvl) begin
      if (lr && !prev_lr) begin
        if (idx >= 0) last_len = idx + 1;
        idx = 0;
      end else if (idx >= 0) idx++;
      for (int l = 0; l < 4; l++) rx[l] = {rx[l][62:0], sd[l]};
      if (idx >= 0 && idx == (cfg_i2s ? 0 : 63) && nfr < 64) begin
        for (int l = 0; l < 4; l++) fr[nfr][l] = rx[l];
        nfr++;
      end
      prev_lr = lr;
    end
    prev_lvl = lvl;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot(input logic [31:0] w, input logic wide);
    return wide ? w : {w[15:0], 16'h0};
  endfunction

  function automatic logic [31:0] mkword(input int seed, input int k);
    return {8'(seed), 8'(k), 8'(k) ^ 8'hC3, 8'(seed) ^ 8'h5A | 8'h01};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_cfg(input logic i2s, input logic binv, input logic linv, input logic c8, input logic wide);
    @(negedge clk);
    cfg_i2s = i2s; cfg_binv = binv; cfg_linv = linv; cfg_c8 = c8; cfg_wide = wide;
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    clr_req++;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    s_valid = 1'b1; s_data = w;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic push_frames(input int seed, input int nframes, input int nch);
    for (int k = 0; k < nframes * nch; k++) begin
      exp_w[k] = mkword(seed, k);
      push(exp_w[k]);
    end
  endtask

  task automatic check_frames(input int nframes, input int nch, input string req, output int f0);
    logic [63:0] e, a;
    f0 = -1;
    for (int f = 0; f < nfr; f++) if (f0 < 0 && (fr[f][0] != 0 || fr[f][1] != 0)) f0 = f;
    chk(f0 >= 0, req, 64'(f0), 64'h0);
    if (f0 < 0) return;
    for (int k = 0; k < nframes; k++)
      for (int l = 0; l < 4; l++) begin
        e = (l < nch / 2) ? {slot(exp_w[k*nch+2*l], cfg_wide), slot(exp_w[k*nch+2*l+1], cfg_wide)} : 64'h0;
        a = (f0 + k < nfr) ? fr[f0+k][l] : 64'hDEAD_DEAD_DEAD_DEAD;
        chk(a == e, req, a, e);
      end
    if (f0 + nframes < nfr)
      chk(fr[f0+nframes][0] == 0, "R9 underrun silent", fr[f0+nframes][0], 64'h0);
  endtask

  task automatic t_reset;
    wait_cyc(2);
    chk(sd == 4'h0, "R1 sd in reset", 64'(sd), 64'h0);
    chk(bclk == 1'b0, "R1 bclk in reset", 64'(bclk), 64'h0);
    chk(lrclk == 1'b0, "R1 R3 i2s left level low", 64'(lrclk), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R1 ready after reset", 64'(s_ready), 64'h1);
  endtask

  task automatic t_stereo_i2s32;
    int f0;
    apply_cfg(1, 0, 0, 0, 1);
    chk(lrclk == 1'b0, "R3 i2s left level", 64'(lrclk), 64'h0);
    push_frames(3, 3, 2);
    wait_cyc(600);
    check_frames(3, 2, "R5 R7 stereo i2s 32b", f0);
  endtask

  task automatic t_stereo_lj16_inv;
    int f0;
    apply_cfg(0, 1, 1, 0, 0);
    chk(bclk == 1'b1, "R4 inverted bclk idle level", 64'(bclk), 64'h1);
    chk(lrclk == 1'b0, "R3 lj left level inverted", 64'(lrclk), 64'h0);
    push_frames(7, 3, 2);
    wait_cyc(600);
    check_frames(3, 2, "R6 R4 stereo lj 16b inverted", f0);
  endtask

  task automatic t_oct(input logic i2s, input logic wide, input int seed);
    int f0;
    apply_cfg(i2s, 0, 1, 1, wide);
    push_frames(seed, 2, 8);
    wait_cyc(600);
    check_frames(2, 8, "R8 eight channel lanes", f0);
  endtask

  task automatic t_buffer;
    int f0, n;
    apply_cfg(0, 0, 0, 0, 1);
    exp_w[0] = 32'h1234_5601; exp_w[1] = 32'h89AB_CD01;
    push(exp_w[0]);
    push(exp_w[1]);
    chk(s_ready == 1'b0, "R9 ready low when buffer full", 64'(s_ready), 64'h0);
    n = 0;
    while (!s_ready && n < 400) begin @(negedge clk); n++; end
    chk(s_ready == 1'b1 && n < 130, "R9 ready back after frame start", 64'(n), 64'd130);
    wait_cyc(400);
    check_frames(1, 2, "R9 buffered frame", f0);
    chk(f0 == 1, "R9 first frame silent", 64'(f0), 64'h1);
  endtask

  task automatic t_hold;
    int f0, toggles, busy;
    logic pb;
    apply_cfg(1, 0, 0, 0, 1);
    @(negedge clk); hold = 1'b1;
    wait_cyc(300);
    chk(s_ready == 1'b0, "R10 ready low while held", 64'(s_ready), 64'h0);
    s_valid = 1'b1; s_data = 32'hBAD0_BAD1;
    toggles = 0; busy = 0; pb = bclk;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      if (s_ready) busy++;
      if (bclk != pb) toggles++;
      pb = bclk;
    end
    chk(busy == 0, "R10 no intake while held", 64'(busy), 64'h0);
    chk(toggles == 256, "R10 bclk runs while held", 64'(toggles), 64'd256);
    busy = 0;
    for (int f = 0; f < nfr; f++) for (int l = 0; l < 4; l++) if (fr[f][l] != 0) busy++;
    chk(busy == 0 && nfr > 2, "R10 held frames silent", 64'(busy), 64'h0);
    hold = 1'b0;
    exp_w[0] = 32'h0F0F_1101; exp_w[1] = 32'h7070_2201;
    push(exp_w[0]);
    push(exp_w[1]);
    wait_cyc(500);
    check_frames(1, 2, "R10 resume after hold", f0);
  endtask

  task automatic t_soft;
    int f0;
    apply_cfg(0, 0, 0, 0, 1);
    push(32'hAAAA_5501);
    wait_cyc(37);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0; clr_req++;
    chk(bclk == 1'b0, "R11 bclk low after soft reset", 64'(bclk), 64'h0);
    chk(lrclk == 1'b1, "R11 left slot after soft reset", 64'(lrclk), 64'h1);
    exp_w[0] = 32'h3C3C_0101; exp_w[1] = 32'hC3C3_0201;
    push(exp_w[0]);
    push(exp_w[1]);
    wait_cyc(500);
    check_frames(1, 2, "R11 partial buffer discarded", f0);
  endtask

  task automatic t_slow_tick;
    int f0, toggles;
    logic pb;
    tick_div = 2;
    apply_cfg(1, 0, 0, 0, 1);
    toggles = 0; pb = bclk;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (bclk != pb) toggles++;
      pb = bclk;
    end
    chk(toggles == 32, "R2 bclk toggles per tick", 64'(toggles), 64'd32);
    push_frames(11, 1, 2);
    wait_cyc(1200);
    chk(last_len == 64, "R2 64 bit periods per frame", 64'(last_len), 64'd64);
    check_frames(1, 2, "R2 slow tick data", f0);
    tick_div = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_stereo_i2s32();
    t_stereo_lj16_inv();
    t_oct(1, 1, 21);
    t_oct(0, 0, 33);
    t_buffer();
    t_hold();
    t_soft();
    t_slow_tick();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule